// File: doc/BRIEF.md
# Debug Trigger and Breakpoint Controller

This block is the control core of an on-chip debug unit. Once armed, it watches for a trigger: either the final-state indication from the comparator sequencer or an immediate trigger written by software. When the trigger arrives, it either issues a breakpoint request straight away or waits for the trace memory to report that the trace session has ended. It issues only one request per armed session. The request leaves on one of two single-cycle outputs, one for background debug mode and one for a software interrupt. The choice depends on a mode-select bit and on whether background debug is available.

The block also counts trace lines stored since arming. The count saturates at the trace depth, and a buffer-full flag is raised at that depth. The flag survives a system reset and is cleared only by arming or by a power-on reset. A 2-bit bank select drives two read views. The first is an 8-byte window onto one of three comparator register banks; the fourth select value maps no bank and reads zero. The second is a single status view that shows one of three control registers, or the match-flag register when the select is 3.

Top module: `dbg_trig_ctl`

## Requirements
- R1: With the breakpoint enable set and tracing off, a final-state indication sampled while armed gives a breakpoint pulse exactly one cycle wide. The pulse is visible in the cycle after the one in which the indication was driven.
- R2: With tracing on (trace enable set, secure low), no breakpoint is issued after the trigger until trace-complete is sampled. The pulse follows in the next cycle.
- R3: An immediate-trigger write acts as a trigger while armed. While not armed it has no effect.
- R4: Once begin-aligned tracing has started, an immediate-trigger write is ignored and no breakpoint comes before trace-complete.
- R5: While secure is high, tracing counts as off: the trace-active output stays low and a trigger gives an immediate breakpoint even with trace enable set.
- R6: Routing:
  - Mode select 1 with background debug enabled goes to the background output.
  - Background debug disabled goes to the software-interrupt output, whatever the mode select.
  - Mode select 0 with background debug enabled issues nothing.
  - The two outputs are never high together.
- R7: Each armed session issues at most one breakpoint, and none while breakpoint enable is clear.
- R8: The line counter increments on each trace-store strobe, saturates at the trace depth (64), and clears when armed or on either reset.
- R9: The full flag sets on the store that brings the count to the depth. It is mirrored as the top bit of the line-count output (bits 6:0 hold the count). While it is set, the valid-line output reads the depth.
- R10: The full flag is unchanged by the system reset. It is cleared only by an arm write or by a power-on reset.
- R11: Bank select 0, 1 and 2 shows banks A, B and C in the window. Window byte i of bank b is bits [(8*b+i)*8 +: 8] of the packed bank input. Select 3 reads zero.
- R12: The status view shows control register 0, 1 or 2 (bits [8*s +: 8] of the control input) for select s < 3, and the match-flag register for select 3.
- R13: The trace-active output is high while armed with end alignment, and while waiting for completion with begin alignment. In both cases tracing must be on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRstN | input | 1 | System reset, active low, async |
| porN | input | 1 | Power-on reset, active low, async |
| armWr | input | 1 | Arm bit written with 1 (one-cycle strobe) |
| trigWr | input | 1 | Immediate-trigger bit written with 1 (strobe) |
| finalState | input | 1 | Comparator sequencer reached its final state |
| traceEn | input | 1 | Tracing enabled |
| alignBegin | input | 1 | 1: trace begins at trigger; 0: trace ends at trigger |
| secure | input | 1 | Secure mode, disables tracing |
| traceDone | input | 1 | Trace session complete |
| traceStore | input | 1 | One trace line stored |
| breakEn | input | 1 | Breakpoint enable |
| bgSel | input | 1 | Breakpoint mode select, 1 = background debug |
| bgEnabled | input | 1 | Background debug available |
| bankSel | input | 2 | Comparator bank / status select |
| winIdx | input | 3 | Byte index inside the window |
| cmpBanks | input | 192 | Packed comparator banks A, B, C |
| ctrlRegs | input | 24 | Packed control registers 0..2 |
| matchFlags | input | 8 | Match-flag register |
| brkBdm | output | 1 | Breakpoint to background debug (pulse) |
| brkSwi | output | 1 | Breakpoint to software interrupt (pulse) |
| traceActive | output | 1 | Trace session running |
| lineCount | output | 8 | {full flag, line count} |
| validLines | output | 7 | Lines holding valid data |
| winData | output | 8 | Selected window byte |
| statusData | output | 8 | Selected status register |

## Verification
The bench builds the block with its defaults: a trace depth of 64, an 8-byte window and 8-bit registers. With these values the counter can be driven all the way through saturation within a few hundred cycles. Every select and index combination of the window can be swept, and the full flag can be seen surviving a system reset while the counter reads zero. Random arm and store traffic is compared against a bench model of the counter, and directed sessions cover each routing combination and both trace alignments.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrLine;
    logic fireBrk;
  } dpStrobe_t;

endpackage

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armWr,
  input  logic       trigWr,
  input  logic       finalState,
  input  logic       traceEn,
  input  logic       alignBegin,
  input  logic       secure,
  input  logic       traceDone,
  input  logic       breakEn,
  output dpStrobe_t  strobe,
  output logic       traceActive
);

  seqState_t state, stateNext;
  logic traceOn;

  assign traceOn = traceEn & ~secure;

  always_comb begin
    stateNext      = state;
    strobe.clrLine = 1'b0;
    strobe.fireBrk = 1'b0;
    if (armWr) begin
      stateNext      = ST_ARMED;
      strobe.clrLine = 1'b1;
    end else begin
      unique case (state)
        ST_ARMED: begin
          if (finalState | trigWr) begin
            if (traceOn) begin
              stateNext = ST_WAIT;
            end else begin
              stateNext      = ST_IDLE;
              strobe.fireBrk = breakEn;
            end
          end
        end
        ST_WAIT: begin
          // trigger writes land here with no effect
          if (traceDone) begin
            stateNext      = ST_IDLE;
            strobe.fireBrk = breakEn;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign traceActive = traceOn &
                       (((state == ST_ARMED) & ~alignBegin) |
                        ((state == ST_WAIT)  &  alignBegin));

endmodule

// File: rtl/dbg_trig_dp.sv
module dbg_trig_dp
  import dbg_trig_pkg::*;
#(
  parameter int LINE_DEPTH = 64,
  parameter int WIN_BYTES  = 8,
  parameter int DATA_W     = 8,
  localparam int CNT_W     = $clog2(LINE_DEPTH) + 1,
  localparam int IDX_W     = $clog2(WIN_BYTES),
  localparam int NUM_BANK  = 3
)(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             porN,
  input  dpStrobe_t                        strobe,
  input  logic                             traceStore,
  input  logic                             bgSel,
  input  logic                             bgEnabled,
  input  logic [1:0]                       bankSel,
  input  logic [IDX_W-1:0]                 winIdx,
  input  logic [NUM_BANK*WIN_BYTES*DATA_W-1:0] cmpBanks,
  input  logic [NUM_BANK*DATA_W-1:0]       ctrlRegs,
  input  logic [DATA_W-1:0]                matchFlags,
  output logic                             brkBdm,
  output logic                             brkSwi,
  output logic [CNT_W:0]                   lineCount,
  output logic [CNT_W-1:0]                 validLines,
  output logic [DATA_W-1:0]                winData,
  output logic [DATA_W-1:0]                statusData
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(LINE_DEPTH);

  logic [CNT_W-1:0] lineCnt;
  logic             bufFull;

  // line counter: cleared by arm and both resets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                lineCnt <= '0;
    else if (strobe.clrLine)                  lineCnt <= '0;
    else if (traceStore && lineCnt < DEPTH_C) lineCnt <= lineCnt + 1'b1;
  end

  // full flag: only power-on reset or arm clear it
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                                          bufFull <= 1'b0;
    else if (strobe.clrLine)                            bufFull <= 1'b0;
    else if (traceStore && lineCnt == DEPTH_C - 1'b1)   bufFull <= 1'b1;
  end

  assign lineCount  = {bufFull, lineCnt};
  assign validLines = bufFull ? DEPTH_C : lineCnt;

  // breakpoint routing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkBdm <= 1'b0;
      brkSwi <= 1'b0;
    end else begin
      brkBdm <= strobe.fireBrk &  bgSel & bgEnabled;
      brkSwi <= strobe.fireBrk & ~bgEnabled;
    end
  end

  // banked window and shared status view
  logic [DATA_W-1:0] bankByte [4][WIN_BYTES];
  logic [DATA_W-1:0] statView [4];

  for (genvar b = 0; b < 4; b++) begin : g_bank
    for (genvar i = 0; i < WIN_BYTES; i++) begin : g_byte
      if (b < NUM_BANK) begin : g_map
        assign bankByte[b][i] = cmpBanks[(b*WIN_BYTES + i)*DATA_W +: DATA_W];
      end else begin : g_none
        assign bankByte[b][i] = '0;
      end
    end
    if (b < NUM_BANK) begin : g_ctl
      assign statView[b] = ctrlRegs[b*DATA_W +: DATA_W];
    end else begin : g_flag
      assign statView[b] = matchFlags;
    end
  end

  assign winData    = bankByte[bankSel][winIdx];
  assign statusData = statView[bankSel];

endmodule

// File: rtl/dbg_trig_ctl.sv
module dbg_trig_ctl
  import dbg_trig_pkg::*;
#(
  parameter int LINE_DEPTH = 64,
  parameter int WIN_BYTES  = 8,
  parameter int DATA_W     = 8,
  localparam int CNT_W     = $clog2(LINE_DEPTH) + 1,
  localparam int IDX_W     = $clog2(WIN_BYTES)
)(
  input  logic                         clk,
  input  logic                         sysRstN,
  input  logic                         porN,
  input  logic                         armWr,
  input  logic                         trigWr,
  input  logic                         finalState,
  input  logic                         traceEn,
  input  logic                         alignBegin,
  input  logic                         secure,
  input  logic                         traceDone,
  input  logic                         traceStore,
  input  logic                         breakEn,
  input  logic                         bgSel,
  input  logic                         bgEnabled,
  input  logic [1:0]                   bankSel,
  input  logic [IDX_W-1:0]             winIdx,
  input  logic [3*WIN_BYTES*DATA_W-1:0] cmpBanks,
  input  logic [3*DATA_W-1:0]          ctrlRegs,
  input  logic [DATA_W-1:0]            matchFlags,
  output logic                         brkBdm,
  output logic                         brkSwi,
  output logic                         traceActive,
  output logic [CNT_W:0]               lineCount,
  output logic [CNT_W-1:0]             validLines,
  output logic [DATA_W-1:0]            winData,
  output logic [DATA_W-1:0]            statusData
);

  logic      rstAllN;
  dpStrobe_t strobe;

  assign rstAllN = sysRstN & porN;

  dbg_trig_seq u_seq (
    .clk        (clk),
    .rstN       (rstAllN),
    .armWr      (armWr),
    .trigWr     (trigWr),
    .finalState (finalState),
    .traceEn    (traceEn),
    .alignBegin (alignBegin),
    .secure     (secure),
    .traceDone  (traceDone),
    .breakEn    (breakEn),
    .strobe     (strobe),
    .traceActive(traceActive)
  );

  dbg_trig_dp #(
    .LINE_DEPTH(LINE_DEPTH),
    .WIN_BYTES (WIN_BYTES),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstAllN),
    .porN      (porN),
    .strobe    (strobe),
    .traceStore(traceStore),
    .bgSel     (bgSel),
    .bgEnabled (bgEnabled),
    .bankSel   (bankSel),
    .winIdx    (winIdx),
    .cmpBanks  (cmpBanks),
    .ctrlRegs  (ctrlRegs),
    .matchFlags(matchFlags),
    .brkBdm    (brkBdm),
    .brkSwi    (brkSwi),
    .lineCount (lineCount),
    .validLines(validLines),
    .winData   (winData),
    .statusData(statusData)
  );

endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk #(
  parameter int LINE_DEPTH = 64,
  parameter int DATA_W     = 8,
  localparam int CNT_W     = $clog2(LINE_DEPTH) + 1
)(
  input logic              clk,
  input logic              sysRstN,
  input logic              porN,
  input logic              armWr,
  input logic              traceStore,
  input logic              brkBdm,
  input logic              brkSwi,
  input logic [1:0]        bankSel,
  input logic [CNT_W:0]    lineCount,
  input logic [CNT_W-1:0]  validLines,
  input logic [DATA_W-1:0] winData
);

  logic             rstAllN;
  logic [CNT_W-1:0] cnt;
  logic             full;

  assign rstAllN = sysRstN & porN;
  assign cnt     = lineCount[CNT_W-1:0];
  assign full    = lineCount[CNT_W];

  p_one_route_r6: assert property (@(posedge clk) disable iff (!rstAllN)
    !(brkBdm && brkSwi));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rstAllN)
    (brkBdm || brkSwi) |=> !(brkBdm || brkSwi));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstAllN)
    cnt <= CNT_W'(LINE_DEPTH));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rstAllN)
    (traceStore && !armWr && cnt < CNT_W'(LINE_DEPTH)) |=> cnt == $past(cnt) + 1'b1);

  p_full_valid_r9: assert property (@(posedge clk) disable iff (!rstAllN)
    full |-> validLines == CNT_W'(LINE_DEPTH));

  p_full_sticky_r10: assert property (@(posedge clk) disable iff (!porN)
    (full && !armWr) |=> full);

  p_empty_window_r11: assert property (@(posedge clk) disable iff (!rstAllN)
    (bankSel == 2'd3) |-> winData == '0);

endmodule

bind dbg_trig_ctl dbg_trig_chk #(
  .LINE_DEPTH(LINE_DEPTH),
  .DATA_W    (DATA_W)
) u_chk (
  .clk       (clk),
  .sysRstN   (sysRstN),
  .porN      (porN),
  .armWr     (armWr),
  .traceStore(traceStore),
  .brkBdm    (brkBdm),
  .brkSwi    (brkSwi),
  .bankSel   (bankSel),
  .lineCount (lineCount),
  .validLines(validLines),
  .winData   (winData)
);

// File: tb/dbg_trig_ctl_bench.sv
module dbg_trig_ctl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic clk = 1'b0;
  logic sysRstN = 1'b0, porN = 1'b0;
  logic armWr = 0, trigWr = 0, finalState = 0, traceEn = 0, alignBegin = 0;
  logic secure = 0, traceDone = 0, traceStore = 0, breakEn = 0;
  logic bgSel = 0, bgEnabled = 0;
  logic [1:0]   bankSel = '0;
  logic [2:0]   winIdx = '0;
  logic [191:0] cmpBanks;
  logic [23:0]  ctrlRegs = {8'hC3, 8'hB2, 8'hA1};
  logic [7:0]   matchFlags = 8'h5E;
  logic brkBdm, brkSwi, traceActive;
  logic [7:0] lineCount;
  logic [6:0] validLines;
  logic [7:0] winData, statusData;

  int nChecks = 0, nFails = 0;
  int bdmCnt = 0, swiCnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_trig_ctl u_dbg_trig_ctl (
    .clk, .sysRstN, .porN, .armWr, .trigWr, .finalState, .traceEn,
    .alignBegin, .secure, .traceDone, .traceStore, .breakEn, .bgSel,
    .bgEnabled, .bankSel, .winIdx, .cmpBanks, .ctrlRegs, .matchFlags,
    .brkBdm, .brkSwi, .traceActive, .lineCount, .validLines, .winData,
    .statusData
  );

  always @(posedge clk) begin
    #2;
    if (brkBdm) bdmCnt++;
    if (brkSwi) swiCnt++;
  end

  function automatic logic [7:0] expWin(int sel, int idx);
    return (sel == 3) ? 8'h00 : 8'((sel*8 + idx)*7 + 3);
  endfunction

  function automatic logic [7:0] expStat(int sel);
    return (sel == 3) ? 8'h5E : 8'(8'hA1 + sel*8'h11);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic armIt();
    armWr = 1; cyc(1); armWr = 0;
  endtask

  task automatic hitFinal();
    finalState = 1; cyc(1); finalState = 0;
  endtask

  task automatic hitSoft();
    trigWr = 1; cyc(1); trigWr = 0;
  endtask

  task automatic stores(int n);
    traceStore = 1; cyc(n); traceStore = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int b0, s0, mCnt, mFull;
    void'($urandom(32'd4242));
    for (int i = 0; i < 24; i++) cmpBanks[i*8 +: 8] = 8'(i*7 + 3);

    cyc(3);
    sysRstN = 1; porN = 1;
    cyc(1);
    check("R1 reset bdm", brkBdm, 0);
    check("R1 reset swi", brkSwi, 0);
    check("R8 reset count", lineCount, 8'h00);
    check("R13 reset trace", traceActive, 0);

    // window and status sweep
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 8; i++) begin
        bankSel = 2'(s); winIdx = 3'(i); #1;
        check("R11 window", winData, expWin(s, i));
      end
      check("R12 status", statusData, expStat(s));
    end

    // R1: immediate breakpoint to background debug, R7 once per session
    breakEn = 1; bgSel = 1; bgEnabled = 1; traceEn = 0;
    armIt();
    b0 = bdmCnt;
    hitFinal();
    check("R1 pulse high", brkBdm, 1);
    check("R6 not swi", brkSwi, 0);
    cyc(1);
    check("R1 pulse low", brkBdm, 0);
    hitFinal(); cyc(2);
    check("R7 one per session", bdmCnt - b0, 1);

    // R3: soft trigger idle vs armed; R6 disabled bdm -> swi
    bgEnabled = 0;
    s0 = swiCnt;
    hitSoft(); cyc(2);
    check("R3 idle trigger ignored", swiCnt - s0, 0);
    armIt();
    hitSoft();
    check("R3 armed trigger", brkSwi, 1);
    check("R6 swi fallback", brkBdm, 0);
    cyc(1);

    // R2/R4/R13: begin-aligned tracing
    bgEnabled = 1; traceEn = 1; alignBegin = 1;
    armIt();
    check("R13 begin idle before trigger", traceActive, 0);
    b0 = bdmCnt;
    hitFinal();
    check("R13 begin active", traceActive, 1);
    check("R2 no early brk", brkBdm, 0);
    cyc(4);
    hitSoft(); cyc(3);
    check("R4 trigger ignored in trace", bdmCnt - b0, 0);
    traceDone = 1; cyc(1); traceDone = 0;
    check("R2 brk after done", brkBdm, 1);
    check("R13 trace ended", traceActive, 0);
    cyc(1);

    // R5/R13: end-aligned with secure
    alignBegin = 0;
    armIt();
    check("R13 end-aligned active", traceActive, 1);
    secure = 1; #1;
    check("R5 secure blocks trace", traceActive, 0);
    hitFinal();
    check("R5 immediate brk when secure", brkBdm, 1);
    cyc(1);
    secure = 0; traceEn = 0;

    // R6: select 0 with bdm enabled -> nothing; select 0 disabled -> swi
    bgSel = 0; bgEnabled = 1;
    b0 = bdmCnt; s0 = swiCnt;
    armIt(); hitFinal(); cyc(2);
    check("R6 suppressed bdm", bdmCnt - b0, 0);
    check("R6 suppressed swi", swiCnt - s0, 0);
    bgEnabled = 0;
    armIt(); hitFinal();
    check("R6 swi select0", brkSwi, 1);
    cyc(1);

    // R7: breakpoint enable clear
    breakEn = 0;
    b0 = bdmCnt; s0 = swiCnt;
    armIt(); hitFinal(); cyc(2);
    check("R7 disabled no brk", (bdmCnt - b0) + (swiCnt - s0), 0);

    // R8/R9/R10: counter and full flag
    armIt();
    stores(DEPTH - 1);
    check("R8 count 63", lineCount, 8'h3F);
    stores(1);
    check("R9 full set", lineCount, 8'hC0);
    check("R9 valid depth", validLines, 7'd64);
    stores(5);
    check("R8 saturate", lineCount, 8'hC0);
    sysRstN = 0; cyc(1); sysRstN = 1; cyc(1);
    check("R10 full survives sysreset", lineCount, 8'h80);
    check("R9 valid while full", validLines, 7'd64);
    armIt();
    check("R10 arm clears", lineCount, 8'h00);
    stores(DEPTH);
    porN = 0; cyc(1); porN = 1; cyc(1);
    check("R10 por clears", lineCount, 8'h00);

    // random traffic against a counter model
    mCnt = 0; mFull = 0;
    for (int k = 0; k < 600; k++) begin
      int st, ar;
      st = ($urandom % 4) != 0;
      ar = ($urandom % 60) == 0;
      traceStore = st[0]; armWr = ar[0];
      bankSel = 2'($urandom % 4); winIdx = 3'($urandom % 8);
      #1;
      check("R11 random window", winData, expWin(int'(bankSel), int'(winIdx)));
      check("R12 random status", statusData, expStat(int'(bankSel)));
      cyc(1);
      if (ar != 0) begin mCnt = 0; mFull = 0; end
      else if (st != 0) begin
        if (mCnt == DEPTH - 1) mFull = 1;
        if (mCnt < DEPTH) mCnt++;
      end
      check("R8 random count", lineCount, {mFull[0], 7'(mCnt)});
      check("R9 random valid", validLines, mFull != 0 ? 7'd64 : 7'(mCnt));
    end
    traceStore = 0; armWr = 0;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule